// File: doc/BRIEF.md
# Transition-Interval Tape Bit Decoder

This block turns a squared tape playback level into a stream of data bits. The level has already passed a hysteresis comparator, so it is a single digital signal. The block brings that level into the system clock domain and makes a one-clock transition pulse for each change of level, whether the level rises or falls. A transition seen while the block is idle opens a measuring window. The window lasts a fixed number of clock-enable ticks. The bit reported for the window depends only on whether a further transition occurred before the window closed.

A further transition inside the window gives a 1. A window that runs out with no further transition gives a 0. The decoded value is loaded into an output register when the window closes, and a valid strobe is raised for one clock at the same time. The tick input sets how fast the window counter advances, so one window length can be matched to the tape data rate without changing the logic.

Top module: `tape_bit_decoder`

## Requirements
- R1: Every change of `rx_level`, rising or falling, is synchronised through `SYNC_STAGES` flops and yields one transition. A change applied before clock edge 1 is acted on at edge `SYNC_STAGES`+1.
- R2: A transition that arrives while idle opens a window with the tick count at zero. Ticks on the opening edge are not counted.
- R3: A window closes on the `WIN_TICKS`-th tick after the edge that opened it. With `tick` held high and `rx_level` changed before edge 1, `bit_valid` is high after edge `WIN_TICKS`+3 when `SYNC_STAGES` is 2.
- R4: If a transition is acted on after the opening edge and before the closing edge, the bit is 1 (`bit_data` = 1).
- R5: If no further transition is acted on before the closing edge, the bit is 0 (`bit_data` = 0).
- R6: Transitions after the first capture in the same window have no effect. Each window yields exactly one strobe.
- R7: A transition acted on at the closing edge is not a capture. It opens the next window at once, with the tick count at zero.
- R8: While `tick` is low the window counter holds. Window length is counted in ticks, not in clocks.
- R9: `bit_valid` is high for exactly one clock per closed window. `bit_data` keeps its value between strobes.
- R10: The synchronous reset `rst` clears `bit_data`, `bit_valid`, the window counter and both flags. A window that was open when reset arrived gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable for the window counter |
| rx_level | input | 1 | Squared tape level, asynchronous to clk |
| bit_data | output | 1 | Last decoded bit |
| bit_valid | output | 1 | One-clock strobe when bit_data is loaded |

## Verification
The bench builds the block with its defaults: a 12-tick window and a two-stage synchroniser. This makes each window at most a few dozen clocks long even when the tick runs at a third of the clock rate. The bench drives the tick as every clock, every second clock and every third clock, and counts ticks itself to predict the closing edge. At these settings a mid-window transition can be placed on the last tick, on the closing edge itself, or repeated inside one window, and a reset can land part way through an open window.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  // True when the count c is the final one before a window of w ticks closes.
  function automatic logic win_last(input int unsigned c, input int unsigned w);
    return c == (w - 1);
  endfunction

  // Width needed to hold counts 0 .. w-1.
  function automatic int unsigned cnt_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/tbd_sync_edge.sv
module tbd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rx_async,
  output logic edge_pulse
);
  localparam int unsigned LAST = STAGES;

  // Shift chain: STAGES synchroniser flops plus one history flop.
  // Not reset, so a steady level never looks like a change after reset.
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[LAST-1:0], rx_async};
  end

  // One clock per level change, either polarity.
  assign edge_pulse = chain[LAST] ^ chain[LAST-1];

endmodule

// File: rtl/tbd_window.sv
module tbd_window #(
  parameter int unsigned WIN = 12,
  parameter int unsigned CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          edge_pulse,
  output logic          armed,
  output logic [CW-1:0] cnt,
  output logic          cap,
  output logic          win_end
);
  logic at_last;

  always_comb begin
    at_last = tbd_pkg::win_last(int'(cnt), WIN);
    win_end = armed && tick && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      cap   <= 1'b0;
    end else if (win_end) begin
      // Closing edge: a coincident transition opens the next window.
      armed <= edge_pulse;
      cnt   <= '0;
      cap   <= 1'b0;
    end else if (!armed) begin
      if (edge_pulse) begin
        armed <= 1'b1;
        cnt   <= '0;
        cap   <= 1'b0;
      end
    end else begin
      if (tick)       cnt <= cnt + 1'b1;
      if (edge_pulse) cap <= 1'b1;
    end
  end

endmodule

// File: rtl/tbd_bit_reg.sv
module tbd_bit_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic din,
  output logic bit_data,
  output logic bit_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_data  <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= load;
      if (load) bit_data <= din;
    end
  end

endmodule

// File: rtl/tape_bit_decoder.sv
module tape_bit_decoder #(
  parameter int unsigned WIN_TICKS   = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_level,
  output logic bit_data,
  output logic bit_valid
);
  localparam int unsigned CNT_W = tbd_pkg::cnt_width(WIN_TICKS);

  // Named internal events, brought out for the checker.
  logic             edge_pulse;
  logic             win_armed;
  logic [CNT_W-1:0] win_cnt;
  logic             win_cap;
  logic             win_end;

  tbd_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rx_async   (rx_level),
    .edge_pulse (edge_pulse)
  );

  tbd_window #(
    .WIN (WIN_TICKS),
    .CW  (CNT_W)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .edge_pulse (edge_pulse),
    .armed      (win_armed),
    .cnt        (win_cnt),
    .cap        (win_cap),
    .win_end    (win_end)
  );

  tbd_bit_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (win_end),
    .din       (win_cap),
    .bit_data  (bit_data),
    .bit_valid (bit_valid)
  );

endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
  parameter int unsigned WIN = 12,
  parameter int unsigned CW  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          edge_pulse,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic          cap,
  input logic          win_end,
  input logic          bit_data,
  input logic          bit_valid
);

  a_r2_arm_on_pulse: assert property (@(posedge clk) disable iff (rst)
    (!armed && edge_pulse) |=> (armed && cnt == '0 && !cap));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    armed |-> (int'(cnt) < WIN));

  a_r3_close_strobes: assert property (@(posedge clk) disable iff (rst)
    win_end |=> bit_valid);

  a_r9_strobe_has_cause: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(win_end));

  a_r4_capture_sets: assert property (@(posedge clk) disable iff (rst)
    (armed && edge_pulse && !win_end) |=> cap);

  a_r7_rearm_on_close: assert property (@(posedge clk) disable iff (rst)
    (win_end && edge_pulse) |=> (armed && cnt == '0 && !cap));

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (armed && !tick) |=> $stable(cnt));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  a_r9_data_holds: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !$past(rst)) |-> $stable(bit_data));

endmodule

bind tape_bit_decoder tbd_checker #(
  .WIN (WIN_TICKS),
  .CW  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .edge_pulse (edge_pulse),
  .armed      (win_armed),
  .cnt        (win_cnt),
  .cap        (win_cap),
  .win_end    (win_end),
  .bit_data   (bit_data),
  .bit_valid  (bit_valid)
);

// File: tb/tape_bit_decoder_tb.sv
module tape_bit_decoder_tb;
  localparam int WIN = 12;
  localparam int NV  = 8;
  // {mid toggle cycle (0 = none), tick period, expected bit}
  localparam logic [12:0] VECS [NV] = '{
    {8'd0,  4'd1, 1'b0},
    {8'd1,  4'd1, 1'b1},
    {8'd5,  4'd1, 1'b1},
    {8'd11, 4'd1, 1'b1},
    {8'd0,  4'd3, 1'b0},
    {8'd20, 4'd3, 1'b1},
    {8'd7,  4'd2, 1'b1},
    {8'd0,  4'd2, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rx = 1'b0;
  logic bit_data, bit_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tape_bit_decoder u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_level(rx),
    .bit_data(bit_data), .bit_valid(bit_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cell: toggle at cycle 0, optional toggle at mid, tick every per clocks.
  task automatic run_cell(input int mid, input int per, input bit exp);
    int tcnt = 0;
    bit seen = 1'b0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (c == 0 || (mid > 0 && c == mid)) rx = ~rx;
      tick = ((c % per) == per - 1);
      @(posedge clk);
      if (c + 1 >= 4 && tick) tcnt++;
      @(negedge clk);
      if (bit_valid) begin
        seen = 1'b1;
        chk(bit_data == exp, exp ? "R4" : "R5", bit_data, exp);
        chk(tcnt == WIN, per == 1 ? "R3" : "R8", tcnt, WIN);
      end
    end
    if (!seen) chk(1'b0, "R3", 0, 1);
    tick = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (bit_valid || bit_data != exp) chk(1'b0, "R9", bit_data, exp);
    end
  endtask

  // Free-running sequence with tick high; records up to two strobes.
  task automatic run_seq(input int ta, input int tb, input int tc, input int rst_at,
                         output int nval, output int e0, output int d0,
                         output int e1, output int d1);
    nval = 0; e0 = -1; d0 = -1; e1 = -1; d1 = -1;
    tick = 1'b1;
    for (int c = 0; c < 45; c++) begin
      if (c == ta || c == tb || c == tc) rx = ~rx;
      if (c == rst_at) rst = 1'b1;
      if (c == rst_at + 2) rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (bit_valid) begin
        if (nval == 0) begin e0 = c + 1; d0 = bit_data; end
        else if (nval == 1) begin e1 = c + 1; d1 = bit_data; end
        nval++;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, e0, d0, e1, d1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(bit_data == 1'b0, "R10", bit_data, 0);
    chk(bit_valid == 1'b0, "R10", bit_valid, 0);

    // Table walk (R3, R4, R5, R8)
    for (int i = 0; i < NV; i++)
      run_cell(int'(VECS[i][12:5]), int'(VECS[i][4:1]), VECS[i][0]);

    // R1: single change of each polarity closes at edge WIN+3 with a 0
    run_seq(0, -1, -1, -10, n, e0, d0, e1, d1);
    chk(n == 1 && e0 == WIN + 3 && d0 == 0, "R1", e0, WIN + 3);
    run_seq(0, -1, -1, -10, n, e0, d0, e1, d1);
    chk(n == 1 && e0 == WIN + 3 && d0 == 0, "R1", e0, WIN + 3);

    // R6: three changes in one window give one strobe carrying 1
    run_seq(0, 3, 6, -10, n, e0, d0, e1, d1);
    chk(n == 1, "R6", n, 1);
    chk(d0 == 1, "R6", d0, 1);

    // R7: change on the closing edge opens the next window
    run_seq(0, WIN, -1, -10, n, e0, d0, e1, d1);
    chk(n == 2, "R7", n, 2);
    chk(e0 == WIN + 3 && d0 == 0, "R7", e0, WIN + 3);
    chk(e1 == 2 * WIN + 3 && d1 == 0, "R7", e1, 2 * WIN + 3);

    // R2: window started by the last tick of a prior one counts from zero
    run_seq(0, WIN, WIN + 5, -10, n, e0, d0, e1, d1);
    chk(n == 2 && e1 == 2 * WIN + 3 && d1 == 1, "R2", e1, 2 * WIN + 3);

    // R10: reset inside an open window clears output and drops the window
    run_cell(4, 1, 1'b1);
    run_seq(0, -1, -1, 6, n, e0, d0, e1, d1);
    chk(n == 0, "R10", n, 0);
    chk(bit_data == 1'b0, "R10", bit_data, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule